// File: doc/BRIEF.md
# Compare-Match Timer

An 8-bit up-counter, clocked through a selectable power-of-two prescaler, that watches for the moment it counts onto a compare value. When that happens, it raises a compare flag and drives an output pin according to a two-bit action code. The action can leave the pin alone, invert it, force it low or force it high. A clear-on-match mode turns the counter into a period generator: the counter spends one clock on the compare value and then returns to zero. An overflow flag reports each wrap from all-ones to zero.

Software reaches the block through a small write/read register port with a two-bit address. It can also drive the pin action by hand with a force strobe, which raises no flag and never clears the counter. A prescaler restart lets software line up the first counter step. Interrupt servicing is represented by two acknowledge inputs, one per flag.

Register map: address 0 is control, with bits [3:0] the clock select, [5:4] the pin action, [6] the waveform-mode lock and [7] clear-on-match. Address 1 is the counter and address 2 is the compare value. Address 3 is command/status: writing bit 0 restarts the prescaler, writing bit 1 forces the compare action, and writing one to bit 4 or bit 5 clears the overflow flag or the compare flag. Reads of address 3 return the overflow flag on bit 4, the compare flag on bit 5, and zero on every other bit.

Top module: `cmp_timer`

## Requirements
- R1: After reset, all four addresses read zero and both flags and the pin are low. Control, counter and compare read back what was last written, and address 3 reads {2'b00, compare flag, overflow flag, 4'b0000}.
- R2: With clock select 0 the counter holds. With clock select k from 1 to 15, the counter advances once every 2^(k-1) clocks, paced by a free-running prescaler.
- R3: Writing one to command bit 0 restarts the prescaler at zero on the next edge. Writing zero there does nothing, and bits 0 and 1 of address 3 always read zero.
- R4: A compare event occurs on the edge where the counter advances to the compare value. The pin action code works as follows: 00 leaves the pin unchanged, 01 inverts it, 10 drives it low and 11 drives it high.
- R5: A compare event sets the compare flag. The flag clears when ack_cmp is high or when one is written to status bit 5. If a set and a clear fall in the same cycle, the set wins.
- R6: A counter advance from 8'hFF to 8'h00 sets the overflow flag. The flag clears when ack_ovf is high or when one is written to status bit 4, and a set wins over a clear in the same cycle.
- R7: With clear-on-match set, the counter goes to zero on the clock after a compare event, whatever the prescaler does. With clear-on-match clear, the counter keeps counting past the compare value.
- R8: Writing one to command bit 1 applies the configured pin action once. It sets no flag and leaves the counter unchanged, even with clear-on-match set.
- R9: While control bit 6 is set, the force strobe has no effect on the pin.
- R10: A software write to the counter takes precedence over counting and over a pending clear, and writing the compare value directly does not produce a compare event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| ack_cmp | input | 1 | Compare interrupt acknowledge |
| oc_pin | output | 1 | Compare output pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |

## Verification
The hardest situation to reach is a compare event that coincides with a pending clear, a force strobe, a software counter write or a flag clear. Each of these needs the counter exactly one step short of the compare value while the stimulus lands on that very clock. Directed sequences place the counter next to the compare value with the prescaler stopped, then enable single-clock counting so the edge of the event is known. Random traffic then keeps clock selects at 0 to 3 and compare values over the whole range, so collisions with writes and acknowledges occur often and are checked against a cycle model in the bench.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CSW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ack_ovf,
  input  logic       ack_cmp,
  output logic       oc_pin,
  output logic       ovf_flag,
  output logic       cmp_flag
);
  localparam int PW = (1 << CSW) - 2;
  localparam logic [PW:0] ONE = {{PW{1'b0}}, 1'b1};
  localparam logic [CSW-1:0] CS_ONE = {{(CSW-1){1'b0}}, 1'b1};

  logic [7:0]    ctrl, count, cmpv;
  logic [PW-1:0] presc;
  logic          clr_pend, pin_q, fo_q, fc_q, pin_nx;

  wire [CSW-1:0] cs       = ctrl[CSW-1:0];
  wire [1:0]     mode     = ctrl[5:4];
  wire           pwm_lock = ctrl[6];
  wire           clr_mode = ctrl[7];

  wire wr_ctrl = we && addr == 2'd0;
  wire wr_cnt  = we && addr == 2'd1;
  wire wr_cmp  = we && addr == 2'd2;
  wire wr_cmd  = we && addr == 2'd3;

  wire [PW:0]   span = (ONE << (cs - CS_ONE)) - ONE;
  wire [PW-1:0] mask = span[PW-1:0];
  wire          tick = (cs != '0) && ((presc & mask) == mask);

  wire [7:0] nxt       = count + 8'd1;
  wire       advance   = tick && !wr_cnt && !clr_pend;
  wire       match_evt = advance && (nxt == cmpv);
  wire       ovf_evt   = advance && (count == 8'hFF);
  wire       force_evt = wr_cmd && wdata[1] && !pwm_lock;
  wire       act       = match_evt || force_evt;

  always_comb begin
    case (mode)
      2'b01:   pin_nx = ~pin_q;
      2'b10:   pin_nx = 1'b0;
      2'b11:   pin_nx = 1'b1;
      default: pin_nx = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      count    <= '0;
      cmpv     <= '0;
      presc    <= '0;
      clr_pend <= 1'b0;
      pin_q    <= 1'b0;
      fo_q     <= 1'b0;
      fc_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wdata;
      if (wr_cmp)  cmpv <= wdata;
      presc <= (wr_cmd && wdata[0]) ? '0 : presc + PW'(1);
      if (wr_cnt)        count <= wdata;
      else if (clr_pend) count <= '0;
      else if (tick)     count <= nxt;
      clr_pend <= match_evt && clr_mode;
      if (act) pin_q <= pin_nx;
      if (match_evt)                            fc_q <= 1'b1;
      else if (ack_cmp || (wr_cmd && wdata[5])) fc_q <= 1'b0;
      if (ovf_evt)                              fo_q <= 1'b1;
      else if (ack_ovf || (wr_cmd && wdata[4])) fo_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl;
      2'd1:    rdata = count;
      2'd2:    rdata = cmpv;
      default: rdata = {2'b00, fc_q, fo_q, 4'b0000};
    endcase
  end

  assign oc_pin   = pin_q;
  assign ovf_flag = fo_q;
  assign cmp_flag = fc_q;

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == '0 && !wr_cnt && !clr_pend) |=> $stable(count));
  // R3
  presc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[0]) |=> (presc == '0));
  // R4
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode == 2'b01) |=> (oc_pin != $past(oc_pin)));
  // R5
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag);
  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (ovf_flag && count == 8'h00));
  // R7
  clr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && clr_mode) |=> ##1 (count == 8'h00 || $past(wr_cnt)));
  // R8
  force_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !match_evt && !cmp_flag) |=> !cmp_flag);
  // R9
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_lock && !match_evt) |=> $stable(oc_pin));
endmodule

// File: tb/sim_cmp_timer.sv
`timescale 1ns/1ps
module sim_cmp_timer;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic oc_pin, ovf_flag, cmp_flag;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_timer u0 (.clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .oc_pin(oc_pin),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  logic [7:0] m_ctrl, m_cnt, m_cmp;
  int unsigned m_pre;
  logic m_pend, m_pin, m_fo, m_fc;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_cnt;
      2'd2: return m_cmp;
      default: return {2'b00, m_fc, m_fo, 4'b0000};
    endcase
  endfunction

  function automatic logic m_tick(input logic [3:0] cs, input int unsigned pre);
    int unsigned per;
    if (cs == 0) return 1'b0;
    per = 1 << (cs - 1);
    return (pre % per) == per - 1;
  endfunction

  function automatic logic m_action(input logic [1:0] md, input logic p);
    if (md == 2'b01) return ~p;
    if (md == 2'b10) return 1'b0;
    if (md == 2'b11) return 1'b1;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_cmp = 0; m_pre = 0;
      m_pend = 0; m_pin = 0; m_fo = 0; m_fc = 0;
    end else begin
      logic wc, cmdw, tk, adv, mt, ov, fr;
      logic [7:0] oc, ocnt;
      oc = m_ctrl; ocnt = m_cnt;
      wc   = we && addr == 2'd1;
      cmdw = we && addr == 2'd3;
      tk   = m_tick(oc[3:0], m_pre);
      adv  = tk && !wc && !m_pend;
      mt   = adv && (8'(ocnt + 1) == m_cmp);
      ov   = adv && ocnt == 8'hFF;
      fr   = cmdw && wdata[1] && !oc[6];
      if (mt || fr) m_pin = m_action(oc[5:4], m_pin);
      if (mt) m_fc = 1; else if (ack_cmp || (cmdw && wdata[5])) m_fc = 0;
      if (ov) m_fo = 1; else if (ack_ovf || (cmdw && wdata[4])) m_fo = 0;
      if (wc) m_cnt = wdata; else if (m_pend) m_cnt = 0; else if (tk) m_cnt = ocnt + 1;
      m_pend = mt && oc[7];
      m_pre = (cmdw && wdata[0]) ? 0 : (m_pre + 1) % (1 << 14);
      if (we && addr == 2'd0) m_ctrl = wdata;
      if (we && addr == 2'd2) m_cmp = wdata;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                      input logic ac, input logic ao);
    we = w; addr = a; wdata = d; ack_cmp = ac; ack_ovf = ao;
    @(posedge clk);
    @(negedge clk);
    check("R1 rdata", rdata, m_read(addr));
    check("R4 oc_pin", {7'b0, oc_pin}, {7'b0, m_pin});
    check("R5 cmp_flag", {7'b0, cmp_flag}, {7'b0, m_fc});
    check("R6 ovf_flag", {7'b0, ovf_flag}, {7'b0, m_fo});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic [1:0] a);
    step(1'b0, a, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #0.5;
      check("R1 reset read", rdata, 8'h00);
    end
    check("R1 reset pin/flags", {5'b0, oc_pin, ovf_flag, cmp_flag}, 8'h00);

    wr(2'd0, 8'h03);
    wr(2'd3, 8'h01);
    check("R3 cmd bits read zero", {6'b0, rdata[1:0]}, 8'h00);
    wr(2'd1, 8'h00);
    for (int i = 0; i < 8; i++) idle(2'd1);
    check("R2 divide by 4 after restart", rdata, 8'h02);

    wr(2'd0, 8'h00);
    for (int i = 0; i < 5; i++) idle(2'd1);
    check("R2 select 0 holds", rdata, 8'h02);

    wr(2'd2, 8'h05);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h91);
    idle(2'd1);
    check("R2 single-clock step", rdata, 8'h04);
    idle(2'd1);
    check("R7 at compare", rdata, 8'h05);
    check("R4 toggle on match", {7'b0, oc_pin}, 8'h01);
    check("R5 flag on match", {7'b0, cmp_flag}, 8'h01);
    idle(2'd1);
    check("R7 cleared next clock", rdata, 8'h00);

    wr(2'd0, 8'h90);
    wr(2'd3, 8'h20);
    check("R5 write-one clear", {7'b0, cmp_flag}, 8'h00);

    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h01);
    idle(2'd1);
    check("R6 wrap sets flag", {7'b0, ovf_flag}, 8'h01);
    check("R6 wrap to zero", rdata, 8'h00);
    step(1'b0, 2'd1, 8'h00, 1'b0, 1'b1);
    check("R6 ack clears", {7'b0, ovf_flag}, 8'h00);

    wr(2'd0, 8'hA0);
    wr(2'd3, 8'h02);
    check("R8 force clears pin", {7'b0, oc_pin}, 8'h00);
    check("R8 force raises no flag", {7'b0, cmp_flag}, 8'h00);
    check("R8 force bit reads zero", {6'b0, rdata[1:0]}, 8'h00);
    idle(2'd1);
    check("R8 force keeps counter", rdata, 8'h02);

    wr(2'd0, 8'h70);
    wr(2'd3, 8'h02);
    check("R9 force locked", {7'b0, oc_pin}, 8'h00);
    wr(2'd0, 8'h30);
    wr(2'd3, 8'h02);
    check("R8 force sets pin", {7'b0, oc_pin}, 8'h01);

    wr(2'd0, 8'h11);
    idle(2'd1);
    wr(2'd1, 8'h05);
    check("R10 write to compare value", rdata, 8'h05);
    check("R10 no event from write", {7'b0, cmp_flag}, 8'h00);
    idle(2'd1);
    check("R10 counting resumes", rdata, 8'h06);
    check("R10 pin untouched", {7'b0, oc_pin}, 8'h01);

    for (int i = 0; i < 6000; i++) begin
      logic w, ac, ao;
      logic [1:0] a;
      logic [7:0] d;
      w  = ($urandom % 100) < 30;
      a  = 2'($urandom);
      d  = 8'($urandom);
      ac = ($urandom % 10) == 0;
      ao = ($urandom % 10) == 0;
      if (w && a == 2'd0) d[3:2] = 2'b00;
      if (w && a == 2'd0 && ($urandom % 4) == 0) d[6] = 1'b0;
      step(w, a, d, ac, ao);
    end
    finish_run();
  end
endmodule